// File: doc/BRIEF.md
# Per-Core Line Age Tracker for One Cache Set

This block holds the replacement bookkeeping for a single set of a shared set-associative cache used by several cores. Every way carries a valid flag, the id of the core that owns the line, and a small saturating age counter that measures how long the line has gone without being touched. The tag lookup, the data array and the victim choice sit outside. The surrounding cache tells the block about each access to the set. Each access carries the accessing core, whether the access hit, and the way concerned: the hit way on a hit, or the way being filled on a miss.

An access only moves the counters of lines that belong to the accessing core. This keeps a core that misses heavily from aging out the lines of a quiet neighbour. A mode pin selects what a tick is. In access counting, each access by a core ages that core's other lines. In miss counting, only that core's misses age them, and the counter ceiling drops from 15 to 7. On a hit, the block reports the age the line had just before it was cleared. This is the measured reuse gap of the line. The block also keeps a most-recent-first order of the cores that have touched the set.

The access input is a plain per-cycle strobe. The block accepts an access on every cycle and never applies back-pressure. The reuse-gap output is a one-cycle valid strobe with no ready, so the consumer must capture it in the cycle it appears. All outputs are registered and change on the clock edge that accepts the access.

Top module: `line_age_tracker`

## Requirements
- R1: While `rst` is high at a clock edge, all valid flags, owners and ages become 0, `gap_valid` becomes 0, and the recency order becomes core 0 in slot 0, core 1 in slot 1, and so on in ascending id.
- R2: A miss access (`acc_hit`=0) by core c to way w sets that way's valid flag to 1, its owner to c and its age to 0. The inserted way is not advanced in that cycle.
- R3: In access-count mode (`count_miss`=0), every access by core c, hit or miss, adds 1 to the age of every other valid way owned by c.
- R4: An access by core c leaves the age of every line owned by a different core unchanged.
- R5: A hit by core c on way w clears that way's age to 0. In the cycle after the access edge, `gap_valid`=1, `gap_value` holds the age the way had just before the hit, and `gap_core`=c.
- R6: `gap_valid` is 0 after any miss access or any cycle with no access.
- R7: Ages saturate and never wrap. In access-count mode an age stops at 15.
- R8: In miss-count mode (`count_miss`=1), core c's other lines advance only on misses by c and not on hits. The age stops at 7; an age already above 7 is held.
- R9: Each access puts the accessing core in slot 0 of the recency order. Cores that were ahead of it move down one slot, and cores behind it keep their slots. Slot k is `rec_order[k*2 +: 2]`.
- R10: A cycle with `acc_valid`=0 leaves all way state and the recency order unchanged.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| count_miss | input | 1 | 0 = age on every access, 1 = age on misses only |
| acc_valid | input | 1 | An access to the set this cycle |
| acc_core | input | 2 | Accessing core id |
| acc_hit | input | 1 | 1 = hit on `acc_way`, 0 = fill into `acc_way` |
| acc_way | input | 2 | Hit way or fill way |
| gap_valid | output | 1 | One-cycle strobe: a reuse gap was measured |
| gap_value | output | 4 | Age of the hit line just before it was cleared |
| gap_core | output | 2 | Core whose hit produced the gap |
| line_valid | output | 4 | Valid flag per way, bit w for way w |
| line_owner | output | 8 | Owner id per way, way w at [w*2 +: 2] |
| line_age | output | 16 | Age per way, way w at [w*4 +: 4] |
| rec_order | output | 8 | Core ids most recent first, slot k at [k*2 +: 2] |

## Verification
Every piece of state leaves the block on an output. A counter that advances for the wrong owner, misses a tick or wraps therefore shows on `line_age` at the first edge after the faulty access, and not only when a later victim choice goes wrong. A stale age also comes out a second time through `gap_value` on the next hit to that line. A fault in the recency shift shows up as a duplicated or lost id in `rec_order` right after the access. Directed sequences therefore check the whole state after each access against a model built from the requirements, and they add spot checks at literal ages, at both ceilings and at the recency permutations.

// File: rtl/age_track_pkg.sv
package age_track_pkg;
  localparam int ACC_AGE_W  = 4;  // counter width used in access-count mode
  localparam int MISS_AGE_W = 3;  // effective width in miss-count mode
  typedef enum logic {COUNT_ACCESS = 1'b0, COUNT_MISS = 1'b1} count_mode_e;
endpackage

// File: rtl/lat_way_state.sv
module lat_way_state #(
  parameter int CW     = 2,
  parameter int AGE_W  = 4,
  parameter int MISS_W = 3
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             count_miss,
  input  logic             acc_valid,
  input  logic [CW-1:0]    acc_core,
  input  logic             acc_hit,
  input  logic             sel,
  output logic             valid_q,
  output logic [CW-1:0]    owner_q,
  output logic [AGE_W-1:0] age_q
);
  import age_track_pkg::*;
  localparam logic [AGE_W-1:0] ACC_MAX  = {AGE_W{1'b1}};
  localparam logic [AGE_W-1:0] MISS_MAX = AGE_W'((1 << MISS_W) - 1);

  logic [AGE_W-1:0] limit;
  logic             mine;
  logic             tick;
  logic             advance;

  assign limit   = (count_mode_e'(count_miss) == COUNT_MISS) ? MISS_MAX : ACC_MAX;
  assign mine    = valid_q && (owner_q == acc_core);
  assign tick    = (count_mode_e'(count_miss) == COUNT_ACCESS) || !acc_hit;
  assign advance = acc_valid && !sel && mine && tick && (age_q < limit);

  always_ff @(posedge clk) begin
    if (rst) begin
      valid_q <= 1'b0;
      owner_q <= '0;
      age_q   <= '0;
    end else if (acc_valid && sel) begin
      age_q <= '0;
      if (!acc_hit) begin
        valid_q <= 1'b1;
        owner_q <= acc_core;
      end
    end else if (advance) begin
      age_q <= age_q + 1'b1;
    end
  end

  // R4: a foreign core's access never moves this line's age
  assert_foreign_hold_R4: assert property (@(posedge clk) disable iff (rst)
    (acc_valid && !sel && owner_q != acc_core) |=> (age_q == $past(age_q)));
  // R7: a saturated counter stays at the top unless the line itself is touched
  assert_no_wrap_R7: assert property (@(posedge clk) disable iff (rst)
    (age_q == ACC_MAX && !(acc_valid && sel)) |=> (age_q == ACC_MAX));
  // R8: in miss counting, hits do not age the other lines
  assert_miss_mode_hold_R8: assert property (@(posedge clk) disable iff (rst)
    (count_miss && acc_valid && acc_hit && !sel) |=> $stable(age_q));
  // R10: an idle cycle changes nothing
  assert_idle_hold_R10: assert property (@(posedge clk) disable iff (rst)
    !acc_valid |=> ($stable(age_q) && $stable(valid_q) && $stable(owner_q)));
  // R2: a fill leaves a valid line at age zero
  assert_fill_fresh_R2: assert property (@(posedge clk) disable iff (rst)
    (acc_valid && sel && !acc_hit) |=> (valid_q && age_q == '0));
endmodule

// File: rtl/lat_core_recency.sv
module lat_core_recency #(
  parameter int CORES = 4,
  parameter int CW    = 2
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          acc_valid,
  input  logic [CW-1:0] acc_core,
  output logic [CW-1:0] order_q [CORES]
);
  logic [CW-1:0] order_d [CORES];
  int            pos;

  always_comb begin
    pos = CORES - 1;
    for (int k = CORES - 1; k >= 0; k--) begin
      if (order_q[k] == acc_core) pos = k;
    end
    order_d[0] = acc_core;
    for (int k = 1; k < CORES; k++) begin
      order_d[k] = (k <= pos) ? order_q[k-1] : order_q[k];
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      for (int k = 0; k < CORES; k++) order_q[k] <= CW'(k);
    end else if (acc_valid) begin
      for (int k = 0; k < CORES; k++) order_q[k] <= order_d[k];
    end
  end

  // R9: the accessing core becomes the most recent
  assert_mru_front_R9: assert property (@(posedge clk) disable iff (rst)
    acc_valid |=> (order_q[0] == $past(acc_core)));
  // R9: the last slot only changes if its core was touched or shifted out
  assert_tail_R9: assert property (@(posedge clk) disable iff (rst)
    (acc_valid && order_q[0] == acc_core) |=> $stable(order_q[CORES-1]));
endmodule

// File: rtl/line_age_tracker.sv
module line_age_tracker #(
  parameter int WAYS   = 4,
  parameter int CORES  = 4,
  parameter int AGE_W  = age_track_pkg::ACC_AGE_W,
  parameter int MISS_W = age_track_pkg::MISS_AGE_W,
  localparam int CW    = $clog2(CORES),
  localparam int WW    = $clog2(WAYS)
) (
  input  logic                  clk,
  input  logic                  rst,
  input  logic                  count_miss,
  input  logic                  acc_valid,
  input  logic [CW-1:0]         acc_core,
  input  logic                  acc_hit,
  input  logic [WW-1:0]         acc_way,
  output logic                  gap_valid,
  output logic [AGE_W-1:0]      gap_value,
  output logic [CW-1:0]         gap_core,
  output logic [WAYS-1:0]       line_valid,
  output logic [WAYS*CW-1:0]    line_owner,
  output logic [WAYS*AGE_W-1:0] line_age,
  output logic [CORES*CW-1:0]   rec_order
);
  logic [AGE_W-1:0] age_arr   [WAYS];
  logic [CW-1:0]    owner_arr [WAYS];
  logic [CW-1:0]    order_arr [CORES];

  for (genvar w = 0; w < WAYS; w++) begin : g_way
    lat_way_state #(.CW(CW), .AGE_W(AGE_W), .MISS_W(MISS_W)) u_way (
      .clk        (clk),
      .rst        (rst),
      .count_miss (count_miss),
      .acc_valid  (acc_valid),
      .acc_core   (acc_core),
      .acc_hit    (acc_hit),
      .sel        (acc_way == WW'(w)),
      .valid_q    (line_valid[w]),
      .owner_q    (owner_arr[w]),
      .age_q      (age_arr[w])
    );
    assign line_owner[w*CW +: CW]       = owner_arr[w];
    assign line_age[w*AGE_W +: AGE_W]   = age_arr[w];
  end

  lat_core_recency #(.CORES(CORES), .CW(CW)) u_rec (
    .clk       (clk),
    .rst       (rst),
    .acc_valid (acc_valid),
    .acc_core  (acc_core),
    .order_q   (order_arr)
  );

  for (genvar k = 0; k < CORES; k++) begin : g_ord
    assign rec_order[k*CW +: CW] = order_arr[k];
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      gap_valid <= 1'b0;
      gap_value <= '0;
      gap_core  <= '0;
    end else begin
      gap_valid <= acc_valid && acc_hit;
      if (acc_valid && acc_hit) begin
        gap_value <= age_arr[acc_way];
        gap_core  <= acc_core;
      end
    end
  end

  // R5: every hit produces a gap strobe carrying the pre-hit age
  assert_gap_strobe_R5: assert property (@(posedge clk) disable iff (rst)
    (acc_valid && acc_hit) |=> (gap_valid && gap_value == $past(age_arr[acc_way])));
  // R6: no strobe without a hit
  assert_gap_quiet_R6: assert property (@(posedge clk) disable iff (rst)
    !(acc_valid && acc_hit) |=> !gap_valid);
endmodule

// File: tb/line_age_tracker_tb.sv
`timescale 1ns/1ps
module line_age_tracker_tb;
  localparam int WAYS = 4, CORES = 4, AW = 4, CW = 2;

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic count_miss = 1'b0;
  logic acc_valid = 1'b0;
  logic [CW-1:0] acc_core = '0;
  logic acc_hit = 1'b0;
  logic [1:0] acc_way = '0;
  logic gap_valid;
  logic [AW-1:0] gap_value;
  logic [CW-1:0] gap_core;
  logic [WAYS-1:0] line_valid;
  logic [WAYS*CW-1:0] line_owner;
  logic [WAYS*AW-1:0] line_age;
  logic [CORES*CW-1:0] rec_order;

  always #2 clk = ~clk;

  line_age_tracker u_dut (
    .clk(clk), .rst(rst), .count_miss(count_miss), .acc_valid(acc_valid),
    .acc_core(acc_core), .acc_hit(acc_hit), .acc_way(acc_way),
    .gap_valid(gap_valid), .gap_value(gap_value), .gap_core(gap_core),
    .line_valid(line_valid), .line_owner(line_owner), .line_age(line_age),
    .rec_order(rec_order)
  );

  int checks = 0, fails = 0;
  bit done = 0;

  // model built from the requirements
  bit m_valid [WAYS];
  int m_owner [WAYS];
  int m_age   [WAYS];
  int m_order [CORES];
  bit e_gv; int e_gval; int e_gcore;

  task automatic chk(string tag, string what, int act, int exp);
    checks++;
    if (act != exp) begin
      fails++;
      $display("FAIL %s %s: actual %0d expected %0d", tag, what, act, exp);
    end
  endtask

  task automatic model_reset();
    for (int w = 0; w < WAYS; w++) begin m_valid[w] = 0; m_owner[w] = 0; m_age[w] = 0; end
    for (int k = 0; k < CORES; k++) m_order[k] = k;
    e_gv = 0; e_gval = 0; e_gcore = 0;
  endtask

  task automatic model_access(int core, bit hit, int way);
    int lim, p;
    lim = count_miss ? 7 : 15;
    e_gv = hit;
    if (hit) begin e_gval = m_age[way]; e_gcore = core; end
    for (int w = 0; w < WAYS; w++) begin
      if (w == way) begin
        m_age[w] = 0;
        if (!hit) begin m_valid[w] = 1; m_owner[w] = core; end
      end else if (m_valid[w] && m_owner[w] == core && (!count_miss || !hit) && m_age[w] < lim) begin
        m_age[w]++;
      end
    end
    p = CORES - 1;
    for (int k = 0; k < CORES; k++) if (m_order[k] == core) begin p = k; break; end
    for (int k = p; k > 0; k--) m_order[k] = m_order[k-1];
    m_order[0] = core;
  endtask

  task automatic check_state(string tag);
    for (int w = 0; w < WAYS; w++) begin
      chk(tag, $sformatf("valid[%0d]", w), int'(line_valid[w]), int'(m_valid[w]));
      if (m_valid[w]) chk(tag, $sformatf("owner[%0d]", w), int'(line_owner[w*CW +: CW]), m_owner[w]);
      chk(tag, $sformatf("age[%0d]", w), int'(line_age[w*AW +: AW]), m_age[w]);
    end
    for (int k = 0; k < CORES; k++)
      chk(tag, $sformatf("order[%0d]", k), int'(rec_order[k*CW +: CW]), m_order[k]);
    chk(tag, "gap_valid", int'(gap_valid), int'(e_gv));
    if (e_gv) begin
      chk(tag, "gap_value", int'(gap_value), e_gval);
      chk(tag, "gap_core", int'(gap_core), e_gcore);
    end
  endtask

  // drive at negedge, apply at posedge, observe at the following negedge
  task automatic acc(int core, bit hit, int way);
    acc_valid = 1; acc_core = CW'(core); acc_hit = hit; acc_way = 2'(way);
    @(posedge clk);
    model_access(core, hit, way);
    @(negedge clk);
    acc_valid = 0;
  endtask

  task automatic idle();
    e_gv = 0;
    @(posedge clk); @(negedge clk);
  endtask

  task automatic do_reset();
    rst = 1; acc_valid = 0;
    @(posedge clk); @(posedge clk); @(negedge clk);
    rst = 0;
    model_reset();
  endtask

  task automatic t_reset();
    acc(1, 0, 2); acc(3, 0, 0);
    do_reset();
    check_state("R1");
    chk("R1", "order slot0 literal", int'(rec_order[1:0]), 0);
    chk("R1", "order slot3 literal", int'(rec_order[7:6]), 3);
    chk("R1", "all invalid", int'(line_valid), 0);
  endtask

  task automatic t_insert();
    do_reset();
    acc(1, 0, 0); check_state("R2");
    acc(2, 0, 1); check_state("R2");
    chk("R2", "way1 owner literal", int'(line_owner[3:2]), 2);
    chk("R6", "no gap after miss", int'(gap_valid), 0);
  endtask

  task automatic t_aging_and_gap();
    do_reset();
    count_miss = 0;
    acc(0, 0, 0); acc(0, 0, 1); acc(0, 0, 2); check_state("R3");
    chk("R3", "way0 age literal", int'(line_age[3:0]), 2);
    acc(0, 1, 0); check_state("R5");
    chk("R5", "gap literal", int'(gap_value), 2);
    chk("R5", "hit way cleared", int'(line_age[3:0]), 0);
    chk("R3", "hit ages others", int'(line_age[7:4]), 2);
    idle(); check_state("R6");
  endtask

  task automatic t_isolation();
    do_reset();
    acc(0, 0, 0); acc(0, 0, 1);
    acc(1, 0, 3);
    for (int i = 0; i < 5; i++) acc(1, 1, 3);
    check_state("R4");
    chk("R4", "core0 way0 untouched", int'(line_age[3:0]), 1);
    chk("R4", "core0 way1 untouched", int'(line_age[7:4]), 0);
  endtask

  task automatic t_saturation();
    do_reset();
    count_miss = 0;
    acc(2, 0, 0);
    for (int i = 0; i < 20; i++) acc(2, 0, 1);
    check_state("R7");
    chk("R7", "saturated at 15", int'(line_age[3:0]), 15);
    acc(2, 1, 0);
    chk("R7", "gap at ceiling", int'(gap_value), 15);
    check_state("R7");
  endtask

  task automatic t_miss_mode();
    do_reset();
    count_miss = 1;
    acc(3, 0, 0); acc(3, 0, 1);
    for (int i = 0; i < 3; i++) acc(3, 1, 1);
    check_state("R8");
    chk("R8", "hits do not age", int'(line_age[3:0]), 1);
    for (int i = 0; i < 10; i++) acc(3, 0, 2);
    check_state("R8");
    chk("R8", "saturated at 7", int'(line_age[3:0]), 7);
    count_miss = 0;
  endtask

  task automatic t_recency();
    do_reset();
    acc(2, 0, 0);
    chk("R9", "after 2 slot0", int'(rec_order[1:0]), 2);
    chk("R9", "after 2 slot1", int'(rec_order[3:2]), 0);
    acc(3, 0, 1); acc(0, 0, 2);
    check_state("R9");
    chk("R9", "order 0,3,2,1", int'(rec_order), (1 << 6) | (2 << 4) | (3 << 2) | 0);
    acc(0, 1, 2);
    chk("R9", "repeat keeps order", int'(rec_order), (1 << 6) | (2 << 4) | (3 << 2) | 0);
  endtask

  task automatic t_idle();
    do_reset();
    acc(1, 0, 0); acc(1, 0, 1); acc(2, 0, 2);
    for (int i = 0; i < 4; i++) idle();
    check_state("R10");
    chk("R10", "age held", int'(line_age[3:0]), 1);
  endtask

  initial begin
    model_reset();
    do_reset();
    t_reset();
    t_insert();
    t_aging_and_gap();
    t_isolation();
    t_saturation();
    t_miss_mode();
    t_recency();
    t_idle();
    done = 1;
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end

  initial begin
    #(200000 * 4);
    if (!done) begin
      checks++; fails++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("%0d/%0d checks passed", checks - fails, checks);
      $finish;
    end
  end
endmodule